// File: doc/BRIEF.md
# Ping-Pong Byte FIFO Pair

This block double-buffers a byte stream between a host port and a bus transfer engine. It holds two byte FIFOs of equal depth. The host reaches one of them through a 16-bit port that carries two bytes per access. The engine moves single bytes in or out of the other FIFO. After the host has filled or drained its buffer, it issues a flip command and the two FIFOs trade roles. The engine can then work on the data the host just staged, and the host gets the buffer the engine just finished.

A flip that arrives while the engine says it is mid-transfer is held. It takes effect on the first clock edge at which the engine reports idle. A host access made in the same cycle as a flip that takes effect is applied to the FIFO that faced the host before the swap. A host write with too little room is dropped, and so is a host read of an empty FIFO. Either case sets a sticky error flag that only reset clears.

Top module: `pp_fifo_pair`

## Requirements
- R1: While reset is asserted, and after it is released, both FIFOs are empty, `fifo_sel` is 0 (FIFO 0 faces the host) and `host_err` is 0. Reset has the same effect at any time, whatever the state.
- R2: A host write stores `host_wdata[7:0]` before `host_wdata[15:0]`'s upper byte, `host_wdata[15:8]`. A host read returns the oldest byte on `host_rdata[7:0]` and the next one on `host_rdata[15:8]`. Byte order is kept on both the host and engine sides.
- R3: Writing DEPTH bytes from the host raises `host_full`, and `host_full` is low just before the last write. Reading all of them back returns the same words and raises `host_empty`.
- R4: A host write with `host_wr_single`=1 stores only `host_wdata[7:0]`. A host read when exactly one byte is present removes only that byte, with `host_rdata[15:8]`=0.
- R5: A flip with `eng_busy`=0 toggles `fifo_sel` at that clock edge. After the flip, the host-side status (`host_empty`, `host_full`) and `alt_empty` describe the swapped FIFOs.
- R6: A flip requested while `eng_busy`=1 leaves `fifo_sel` unchanged for as long as `eng_busy` stays 1. It then toggles at the first edge with `eng_busy`=0.
- R7: A host write that needs more free slots than remain is ignored. A host read when the host FIFO is empty is ignored. Either one sets `host_err`, which stays 1 until reset.
- R8: A host access in the same cycle as an effective flip acts on the FIFO that faced the host before the swap.
- R9: The engine pushes and pops one byte per cycle on the alternate FIFO, with `eng_rdata` showing its oldest byte. An engine push to a full FIFO is ignored. An engine pop of an empty FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data, low byte first |
| host_wr_single | input | 1 | Only the low byte of this write is valid |
| host_rd | input | 1 | Host read strobe, removes up to two bytes |
| host_rdata | output | 16 | Oldest two host-side bytes (show-ahead) |
| host_flip | input | 1 | Request to swap FIFO roles |
| host_empty | output | 1 | Host-side FIFO is empty |
| host_full | output | 1 | Host-side FIFO is full |
| alt_empty | output | 1 | Engine-side FIFO is empty |
| host_err | output | 1 | Sticky flag for a rejected host access |
| fifo_sel | output | 1 | Index of the FIFO facing the host |
| eng_push | input | 1 | Engine pushes one byte |
| eng_wdata | input | 8 | Engine write byte |
| eng_pop | input | 1 | Engine pops one byte |
| eng_rdata | output | 8 | Oldest engine-side byte (show-ahead) |
| eng_busy | input | 1 | Engine is mid-transfer; defers a flip |

## Verification
The sensitive coincidence is a host write and a role swap at the same clock edge. The stimulus raises `host_wr` and `host_flip` together while the engine is idle. The bench then expects the written bytes to appear on the engine side after the swap, not on the host side. The other coincidence is a flip held across several busy cycles. It is judged by sampling `fifo_sel` in every held cycle and on the first idle edge, then reading back the bytes the engine staged before the swap.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;

    localparam logic [1:0] XFER_NONE = 2'd0;
    localparam logic [1:0] XFER_ONE  = 2'd1;
    localparam logic [1:0] XFER_TWO  = 2'd2;

    // Access request presented to one byte FIFO in a cycle.
    typedef struct packed {
        logic [1:0]  push_n;   // bytes written: 0, 1 or 2
        logic [15:0] wdata;    // [7:0] goes in first
        logic [1:0]  pop_n;    // bytes removed: 0, 1 or 2
    } fifo_req_t;

endpackage

// File: rtl/pp_byte_fifo.sv
module pp_byte_fifo
    import pp_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_req_t     req,
    output logic [7:0]    head_lo,
    output logic [7:0]    head_hi,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (req.push_n != XFER_NONE) begin
            s_d.mem[s_q.wp] = req.wdata[7:0];
        end
        if (req.push_n == XFER_TWO) begin
            s_d.mem[s_q.wp + AW'(1)] = req.wdata[15:8];
        end
        s_d.wp  = s_q.wp + AW'(req.push_n);
        s_d.rp  = s_q.rp + AW'(req.pop_n);
        s_d.cnt = s_q.cnt + CW'(req.push_n) - CW'(req.pop_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_lo = s_q.mem[s_q.rp];
    assign head_hi = s_q.mem[s_q.rp + AW'(1)];
    assign count   = s_q.cnt;

    // The gating in the parent must never let a FIFO over- or under-run.
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(s_q.cnt) + int'(req.push_n) <= DEPTH)); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req.pop_n) <= int'(s_q.cnt))); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(s_q.cnt) <= DEPTH)); // R3

endmodule

// File: rtl/pp_flip_ctrl.sv
module pp_flip_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_req,
    input  logic eng_busy,
    output logic sel
);

    typedef struct packed {
        logic sel;
        logic pend;
    } flip_st_t;

    flip_st_t s_d, s_q;
    logic     want;

    always_comb begin
        s_d  = s_q;
        want = flip_req | s_q.pend;
        if (want && !eng_busy) begin
            s_d.sel  = ~s_q.sel;
            s_d.pend = 1'b0;
        end else begin
            s_d.pend = want;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel = s_q.sel;

    AST_FLIP_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> $stable(s_q.sel)); // R6
    AST_FLIP_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !eng_busy) |=> (s_q.sel != $past(s_q.sel))); // R6
    AST_FLIP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_req && !eng_busy) |=> (s_q.sel != $past(s_q.sel))); // R5

endmodule

// File: rtl/pp_fifo_pair.sv
module pp_fifo_pair
    import pp_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [15:0] host_wdata,
    input  logic        host_wr_single,
    input  logic        host_rd,
    output logic [15:0] host_rdata,
    input  logic        host_flip,
    output logic        host_empty,
    output logic        host_full,
    output logic        alt_empty,
    output logic        host_err,
    output logic        fifo_sel,
    input  logic        eng_push,
    input  logic [7:0]  eng_wdata,
    input  logic        eng_pop,
    output logic [7:0]  eng_rdata,
    input  logic        eng_busy
);

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t       s_d, s_q;
    logic          sel;
    logic [CW-1:0] fifo_cnt [2];
    logic [7:0]    fifo_lo  [2];
    logic [7:0]    fifo_hi  [2];
    fifo_req_t     fifo_req [2];
    fifo_req_t     host_req, eng_req;

    logic [CW-1:0] host_cnt, alt_cnt;
    logic [1:0]    wr_need, rd_take;
    logic          host_wr_ok, host_rd_ok, eng_push_ok, eng_pop_ok;

    always_comb begin
        host_cnt    = fifo_cnt[sel];
        alt_cnt     = fifo_cnt[~sel];
        wr_need     = host_wr_single ? XFER_ONE : XFER_TWO;
        rd_take     = (host_cnt >= CW'(2)) ? XFER_TWO : XFER_ONE;
        host_wr_ok  = host_wr && ((CW'(DEPTH) - host_cnt) >= CW'(wr_need));
        host_rd_ok  = host_rd && (host_cnt != '0);
        eng_push_ok = eng_push && (alt_cnt != CW'(DEPTH));
        eng_pop_ok  = eng_pop && (alt_cnt != '0);

        host_req.push_n = host_wr_ok ? wr_need : XFER_NONE;
        host_req.wdata  = host_wdata;
        host_req.pop_n  = host_rd_ok ? rd_take : XFER_NONE;

        eng_req.push_n  = eng_push_ok ? XFER_ONE : XFER_NONE;
        eng_req.wdata   = {8'h00, eng_wdata};
        eng_req.pop_n   = eng_pop_ok ? XFER_ONE : XFER_NONE;

        s_d     = s_q;
        s_d.err = s_q.err | (host_wr && !host_wr_ok) | (host_rd && !host_rd_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    pp_flip_ctrl u_flip (
        .clk      (clk),
        .rst_n    (rst_n),
        .flip_req (host_flip),
        .eng_busy (eng_busy),
        .sel      (sel)
    );

    for (genvar g = 0; g < 2; g++) begin : g_fifo
        assign fifo_req[g] = (sel == 1'(g)) ? host_req : eng_req;

        pp_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (fifo_req[g]),
            .head_lo (fifo_lo[g]),
            .head_hi (fifo_hi[g]),
            .count   (fifo_cnt[g])
        );
    end

    assign host_rdata = {(host_cnt >= CW'(2)) ? fifo_hi[sel] : 8'h00, fifo_lo[sel]};
    assign eng_rdata  = fifo_lo[~sel];
    assign host_empty = (host_cnt == '0);
    assign host_full  = (host_cnt == CW'(DEPTH));
    assign alt_empty  = (alt_cnt == '0);
    assign host_err   = s_q.err;
    assign fifo_sel   = sel;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> host_err); // R7
    AST_RD_EMPTY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_empty) |=> host_err); // R7
    AST_WR_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_full && host_wr && !host_rd && !host_flip) |=> (host_full && host_err)); // R7

endmodule

// File: tb/pp_fifo_pair_tb.sv
`timescale 1ns/100ps
module pp_fifo_pair_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_wr_single, host_rd, host_flip;
    logic [15:0] host_wdata, host_rdata;
    logic        host_empty, host_full, alt_empty, host_err, fifo_sel;
    logic        eng_push, eng_pop, eng_busy;
    logic [7:0]  eng_wdata, eng_rdata;

    logic [7:0]  q0 [$];
    logic [7:0]  q1 [$];
    int          bsel;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pp_fifo_pair #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_wr_single(host_wr_single),
        .host_rd(host_rd), .host_rdata(host_rdata), .host_flip(host_flip),
        .host_empty(host_empty), .host_full(host_full), .alt_empty(alt_empty),
        .host_err(host_err), .fifo_sel(fifo_sel),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
        .eng_rdata(eng_rdata), .eng_busy(eng_busy)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qpush(int idx, logic [7:0] b);
        if (idx == 0) q0.push_back(b); else q1.push_back(b);
    endtask

    task automatic qpop(int idx, output logic [7:0] b, output bit ok);
        ok = 1'b1;
        b  = 8'h00;
        if (idx == 0) begin
            if (q0.size() == 0) ok = 1'b0; else b = q0.pop_front();
        end else begin
            if (q1.size() == 0) ok = 1'b0; else b = q1.pop_front();
        end
    endtask

    function automatic int qsize(int idx);
        return (idx == 0) ? q0.size() : q1.size();
    endfunction

    // Monitor: compares outputs against the scoreboard before the consuming edge.
    always @(negedge clk) begin
        #1.5;
        if (rst_n === 1'b1) begin
            if (host_rd && qsize(bsel) > 0) begin
                logic [7:0] lo, hi;
                bit ok;
                int n;
                n = (qsize(bsel) >= 2) ? 2 : 1;
                qpop(bsel, lo, ok);
                hi = 8'h00;
                if (n == 2) qpop(bsel, hi, ok);
                chk("R2 host read word", host_rdata, {hi, lo});
            end
            if (eng_pop && qsize(1 - bsel) > 0) begin
                logic [7:0] b;
                bit ok;
                qpop(1 - bsel, b, ok);
                chk("R9 engine read byte", {8'h00, eng_rdata}, {8'h00, b});
            end
        end
    end

    task automatic hwrite(logic [15:0] w, bit single, bit accept);
        host_wr = 1'b1; host_wdata = w; host_wr_single = single;
        if (accept) begin
            qpush(bsel, w[7:0]);
            if (!single) qpush(bsel, w[15:8]);
        end
        @(negedge clk);
        host_wr = 1'b0; host_wr_single = 1'b0;
    endtask

    task automatic hread();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic epush(logic [7:0] b, bit accept);
        eng_push = 1'b1; eng_wdata = b;
        if (accept) qpush(1 - bsel, b);
        @(negedge clk);
        eng_push = 1'b0;
    endtask

    task automatic epop();
        eng_pop = 1'b1;
        @(negedge clk);
        eng_pop = 1'b0;
    endtask

    task automatic flip_now();
        host_flip = 1'b1;
        @(negedge clk);
        host_flip = 1'b0;
        bsel = 1 - bsel;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bsel = 0;
        host_wr = 1'b0; host_wdata = '0; host_wr_single = 1'b0; host_rd = 1'b0;
        host_flip = 1'b0; eng_push = 1'b0; eng_wdata = '0; eng_pop = 1'b0; eng_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 host_empty", 16'(host_empty), 16'd1);
        chk("R1 host_full", 16'(host_full), 16'd0);
        chk("R1 alt_empty", 16'(alt_empty), 16'd1);
        chk("R1 fifo_sel", 16'(fifo_sel), 16'd0);
        chk("R1 host_err", 16'(host_err), 16'd0);

        // R3: fill with DEPTH bytes
        for (int i = 0; i < DEPTH/2 - 1; i++) hwrite(16'(16'h1100 * (i + 1) + 16'(i)), 1'b0, 1'b1);
        chk("R3 not full before last", 16'(host_full), 16'd0);
        hwrite(16'hA55A, 1'b0, 1'b1);
        chk("R3 full", 16'(host_full), 16'd1);

        // R7: writes when full are dropped and flagged
        hwrite(16'hDEAD, 1'b0, 1'b0);
        hwrite(16'h00EE, 1'b1, 1'b0);
        chk("R7 still full", 16'(host_full), 16'd1);
        chk("R7 err after overflow", 16'(host_err), 16'd1);

        // R3: read all back, data compared by the monitor
        for (int i = 0; i < DEPTH/2; i++) hread();
        chk("R3 empty after drain", 16'(host_empty), 16'd1);
        hread();
        chk("R7 empty read keeps empty", 16'(host_empty), 16'd1);
        chk("R7 err sticky", 16'(host_err), 16'd1);

        // R4, R5: odd byte count then flip to the engine
        hwrite(16'h2211, 1'b0, 1'b1);
        hwrite(16'h4433, 1'b0, 1'b1);
        hwrite(16'hFF55, 1'b1, 1'b1);
        flip_now();
        chk("R5 sel after flip", 16'(fifo_sel), 16'd1);
        chk("R5 host side empty", 16'(host_empty), 16'd1);
        chk("R5 alt not empty", 16'(alt_empty), 16'd0);
        for (int i = 0; i < 4; i++) epop();
        chk("R4 one byte left", 16'(alt_empty), 16'd0);
        epop();
        chk("R4 alt empty after 5 bytes", 16'(alt_empty), 16'd1);
        epop();
        chk("R9 pop of empty ignored", 16'(alt_empty), 16'd1);

        // R6: flip deferred while engine busy
        epush(8'hB0, 1'b1);
        epush(8'hB1, 1'b1);
        epush(8'hB2, 1'b1);
        host_flip = 1'b1; eng_busy = 1'b1;
        @(negedge clk);
        host_flip = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R6 sel held while busy", 16'(fifo_sel), 16'd1);
            @(negedge clk);
        end
        eng_busy = 1'b0;
        @(negedge clk);
        chk("R6 sel after busy drops", 16'(fifo_sel), 16'd0);
        bsel = 0;
        chk("R6 host sees staged bytes", 16'(host_empty), 16'd0);
        hread();
        hread();
        chk("R4 host empty after odd read", 16'(host_empty), 16'd1);

        // R8: write and flip in the same cycle
        host_wr = 1'b1; host_wdata = 16'hBEEF; host_flip = 1'b1;
        qpush(bsel, 8'hEF); qpush(bsel, 8'hBE);
        @(negedge clk);
        host_wr = 1'b0; host_flip = 1'b0; bsel = 1 - bsel;
        chk("R8 sel toggled", 16'(fifo_sel), 16'd1);
        chk("R8 new host side empty", 16'(host_empty), 16'd1);
        chk("R8 data went to old side", 16'(alt_empty), 16'd0);
        epop();
        epop();
        chk("R8 alt drained", 16'(alt_empty), 16'd1);

        // R9: engine fills alternate FIFO, extra push dropped
        for (int i = 0; i < DEPTH; i++) epush(8'(i * 7 + 3), 1'b1);
        epush(8'h99, 1'b0);
        flip_now();
        chk("R9 host full after engine fill", 16'(host_full), 16'd1);
        for (int i = 0; i < DEPTH/2; i++) hread();
        chk("R9 host empty after drain", 16'(host_empty), 16'd1);

        // R1: reset from a busy state
        hwrite(16'h7788, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        q0.delete(); q1.delete(); bsel = 0;
        chk("R1 reset host_empty", 16'(host_empty), 16'd1);
        chk("R1 reset alt_empty", 16'(alt_empty), 16'd1);
        chk("R1 reset sel", 16'(fifo_sel), 16'd0);
        chk("R1 reset err", 16'(host_err), 16'd0);
        hread();
        chk("R7 empty read sets err", 16'(host_err), 16'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule